// File: doc/BRIEF.md
# Serial PMIC Register Bridge

This block lets a host reach the registers of a power-management companion chip as if they were local memory-mapped registers. A write is posted. The host stores a 16-bit value into an address window, and the bridge queues the slave address and data in a small write queue. The queue then drains, one entry at a time, onto a four-wire serial link: chip select, clock, data out and data in.

A read takes two steps. The host writes the slave byte offset into a command register, and that write alone launches the read. The host then polls a result register. The result register holds a busy flag, an echo of the slave address that was requested and, once the transfer is complete, the 16-bit value returned by the slave. The host compares the echoed address with the address it asked for, which tells it that the data belongs to its own request.

The host can see whether the write queue is full or empty. A store that arrives when the queue is full is dropped and sets a sticky overflow flag. A configuration bit chooses between two serial clock modes: the clock runs all the time, or it stops whenever the link is idle. Every serial frame is 32 bits long. The first bit gives the direction (1 for read), the next 15 bits carry the slave word address and the last 16 bits carry the data. Bits go out MSB first. Data out changes while the clock is low, and both sides sample on the rising clock.

Top module: `pmic_serial_bridge`

## Requirements
- R1: After reset, the result register (0x2C) reads 0x00000000, the queue status register (0x30) reads 0x00000400 (empty only) and the configuration register (0x20) reads 0. Chip select is high and the serial clock is low.
- R2: A write to the command register (0x28) starts a read with no further action. From the next cycle on, result bit 31 (busy) reads 1 and bits 30:16 hold the slave word address, which is bits 16:2 of the written offset.
- R3: A read sends a frame with direction bit 1, the word address and 16 zero bits. When the frame ends, busy clears and result bits 15:0 hold the 16 bits the slave returned on data in.
- R4: A read frame does not start until the write queue is empty. A read issued right after posted stores therefore returns the value written by the last of those stores.
- R5: A store to window base 0x8000 + offset, where the offset is below the window size of 0x4000, sends a write frame. The frame carries direction bit 0, word address offset[16:2] and data from bits 15:0 of the store. Stores leave in the order they were made.
- R6: Status bit 11 reads 1 while the queue holds its full depth of 4 entries. Status bit 10 reads 1 while the queue holds no entries.
- R7: A store made while the queue is full is dropped: no frame is ever sent for it. It also sets status bit 12 (overflow), which stays set until the host writes a 1 to bit 12 of 0x30.
- R8: A store to an address outside the window is ignored. The queue stays empty and no frame is sent.
- R9: A write to the command register while busy reads 1 is ignored. The read already in flight finishes with its own address echo and data, and no second frame is sent.
- R10: During a frame, chip select stays low for exactly 32 rising edges of the serial clock. Data out does not change while the clock is high.
- R11: While configuration bit 30 is 0, the serial clock stays low whenever chip select is high. While it is 1, the serial clock keeps toggling between frames. Bit 30 reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per write |
| bus_we | input | 1 | Host write enable |
| bus_addr | input | ABUS_W | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, decoded from bus_addr |
| ser_csn | output | 1 | Serial chip select, active low |
| ser_sclk | output | 1 | Serial clock |
| ser_mosi | output | 1 | Serial data to the slave |
| ser_miso | input | 1 | Serial data from the slave |

## Verification
The assertions check the following on every cycle:
- an accepted read command raises busy;
- a read frame never starts while the write queue still holds entries;
- the full and empty flags are never both set;
- a dropped store always leaves the overflow flag set;
- the clock stays low while idle with gating enabled;
- data out stays stable through each clock-high phase.

Other behaviours only the bench scenarios can show, using a behavioural slave register file:
- the value and the address echo a read returns;
- the order of posted writes against a later read;
- that a dropped store never reaches the slave;
- that stores outside the window and repeated read commands leave no trace.

// File: rtl/pmic_serial_bridge.sv
module pmic_serial_bridge #(
  parameter int ABUS_W     = 18,
  parameter int WIN_BASE   = 'h8000,
  parameter int WIN_SIZE   = 'h4000,
  parameter int WORD_ADDR  = 1,
  parameter int FIFO_DEPTH = 4,
  parameter int SCLK_HALF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ABUS_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ser_csn,
  output logic              ser_sclk,
  output logic              ser_mosi,
  input  logic              ser_miso
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int DW = $clog2(SCLK_HALF + 1);
  localparam logic [31:0] A_CFG  = 32'h20;
  localparam logic [31:0] A_CMD  = 32'h28;
  localparam logic [31:0] A_RES  = 32'h2C;
  localparam logic [31:0] A_STAT = 32'h30;
  localparam logic [31:0] WIN_LO = 32'(WIN_BASE);
  localparam logic [31:0] WIN_HI = 32'(WIN_BASE + WIN_SIZE);

  function automatic logic [14:0] slv_addr(input logic [31:0] v);
    return (WORD_ADDR != 0) ? v[16:2] : v[14:0];
  endfunction

  logic [31:0] addr32, win_off;
  logic        wr, in_win, cmd_wr, push, drop;
  assign addr32  = 32'(bus_addr);
  assign win_off = addr32 - WIN_LO;
  assign wr      = bus_sel & bus_we;
  assign in_win  = (addr32 >= WIN_LO) && (addr32 < WIN_HI);

  logic          cfg_on, ovf;
  logic          rd_busy, rd_pend;
  logic [14:0]   rd_echo;
  logic [15:0]   rd_val;

  logic [30:0]   fifo_q [FIFO_DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          fifo_full, fifo_empty;
  assign fifo_full  = (count == CW'(FIFO_DEPTH));
  assign fifo_empty = (count == '0);

  logic          shifting, is_rd, sclk_q, csn_q;
  logic [31:0]   sh_q;
  logic [4:0]    bit_cnt;
  logic [DW-1:0] div_q;
  logic [15:0]   rx_q;
  logic          start_rd, start_wr, tick, frame_done;

  assign cmd_wr     = wr && (addr32 == A_CMD) && !rd_busy;
  assign push       = wr && in_win && !fifo_full;
  assign drop       = wr && in_win && fifo_full;
  assign start_wr   = !shifting && !fifo_empty;
  assign start_rd   = !shifting && rd_pend && fifo_empty;
  assign tick       = shifting && (div_q == DW'(SCLK_HALF - 1));
  assign frame_done = tick && sclk_q && (bit_cnt == 5'd31);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) fifo_q[wr_ptr] <= {slv_addr(win_off), bus_wdata[15:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)     wr_ptr <= ptr_next(wr_ptr);
      if (start_wr) rd_ptr <= ptr_next(rd_ptr);
      case ({push, start_wr})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_on  <= 1'b0;
      ovf     <= 1'b0;
      rd_busy <= 1'b0;
      rd_pend <= 1'b0;
      rd_echo <= '0;
      rd_val  <= '0;
    end else begin
      if (wr && addr32 == A_CFG) cfg_on <= bus_wdata[30];
      if (drop) ovf <= 1'b1;
      else if (wr && addr32 == A_STAT && bus_wdata[12]) ovf <= 1'b0;
      if (cmd_wr) begin
        rd_busy <= 1'b1;
        rd_pend <= 1'b1;
        rd_echo <= slv_addr(bus_wdata);
      end
      if (start_rd) rd_pend <= 1'b0;
      if (frame_done && is_rd) begin
        rd_busy <= 1'b0;
        rd_val  <= rx_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifting <= 1'b0;
      is_rd    <= 1'b0;
      sclk_q   <= 1'b0;
      csn_q    <= 1'b1;
      sh_q     <= '0;
      bit_cnt  <= '0;
      div_q    <= '0;
      rx_q     <= '0;
    end else if (start_wr || start_rd) begin
      shifting <= 1'b1;
      is_rd    <= start_rd;
      sclk_q   <= 1'b0;
      csn_q    <= 1'b0;
      bit_cnt  <= '0;
      div_q    <= '0;
      sh_q     <= start_rd ? {1'b1, rd_echo, 16'h0000} : {1'b0, fifo_q[rd_ptr]};
    end else if (shifting) begin
      if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[14:0], ser_miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_cnt == 5'd31) begin
            shifting <= 1'b0;
            csn_q    <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh_q    <= {sh_q[30:0], 1'b0};
          end
        end
      end
    end else begin
      sclk_q <= cfg_on ? ~sclk_q : 1'b0;
    end
  end

  assign ser_csn  = csn_q;
  assign ser_sclk = sclk_q;
  assign ser_mosi = csn_q ? 1'b0 : sh_q[31];

  always_comb begin
    case (addr32)
      A_CFG:   bus_rdata = {1'b0, cfg_on, 30'd0};
      A_RES:   bus_rdata = {rd_busy, rd_echo, rd_val};
      A_STAT:  bus_rdata = {19'd0, ovf, fifo_full, fifo_empty, 10'd0};
      default: bus_rdata = 32'd0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, win_off};
endmodule

// File: rtl/pmic_bridge_chk.sv
module pmic_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr,
  input logic rd_busy,
  input logic start_rd,
  input logic fifo_empty,
  input logic fifo_full,
  input logic drop,
  input logic ovf,
  input logic csn,
  input logic sclk,
  input logic mosi,
  input logic cfg_on
);
  a_r2_busy_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> rd_busy);

  a_r4_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |-> fifo_empty);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  a_r7_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);

  a_r11_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && !cfg_on && !$past(cfg_on)) |-> !sclk);

  a_r10_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && sclk && $past(!csn && sclk)) |-> $stable(mosi));
endmodule

bind pmic_serial_bridge pmic_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .rd_busy(rd_busy),
  .start_rd(start_rd), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .drop(drop), .ovf(ovf), .csn(ser_csn), .sclk(ser_sclk),
  .mosi(ser_mosi), .cfg_on(cfg_on)
);

// File: tb/pmic_serial_bridge_tb.sv
module pmic_serial_bridge_tb;
  localparam int WB = 'h8000;
  localparam int WS = 'h4000;
  localparam logic [31:0] VEC [6] = '{
    32'h0004_A1B2, 32'h0010_3C4D, 32'h00FC_FFFF,
    32'h0040_0001, 32'h3FFC_8000, 32'h0000_7E81 };

  logic clk = 0, rst_n = 0, b_sel = 0, b_we = 0;
  logic [17:0] b_addr = '0;
  logic [31:0] b_wdata = '0, rdata;
  logic csn, sclk, mosi, miso;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmic_serial_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_we(b_we),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata),
    .ser_csn(csn), .ser_sclk(sclk), .ser_mosi(mosi), .ser_miso(miso));

  // behavioural slave register file
  logic [15:0] smem [64];
  logic [31:0] s_in = '0;
  logic [15:0] s_out = '0;
  int s_cnt = 0, frames = 0, frame_err = 0, mosi_err = 0, idle_edges = 0;
  logic last_rw = 0;
  logic [14:0] last_addr = '0;
  logic [15:0] last_data = '0;
  logic s_miso = 0;
  assign miso = s_miso;

  initial for (int i = 0; i < 64; i++) smem[i] = 16'h5A00 + 16'(i);

  always @(posedge sclk or posedge csn) begin
    if (csn) begin
      if (s_cnt != 0 && s_cnt != 32) frame_err++;
      s_cnt = 0;
      if (sclk) idle_edges++;
    end else begin
      s_in = {s_in[30:0], mosi};
      s_cnt++;
      if (s_cnt == 16) s_out = smem[s_in[5:0]];
      if (s_cnt == 32) begin
        frames++;
        last_rw = s_in[31]; last_addr = s_in[30:16]; last_data = s_in[15:0];
        if (!s_in[31]) smem[s_in[21:16]] = s_in[15:0];
      end
    end
  end

  always @(negedge sclk)
    if (!csn && s_cnt >= 16 && s_cnt < 32) s_miso = s_out[31 - s_cnt];

  logic p_hi = 0, p_mosi = 0;
  always @(negedge clk) begin
    if (!csn && sclk && p_hi && mosi != p_mosi) mosi_err++;
    p_hi = !csn && sclk;
    p_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    b_sel = 1; b_we = 1; b_addr = 18'(a); b_wdata = d;
    @(negedge clk);
    b_sel = 0; b_we = 0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    b_addr = 18'(a);
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st, rs;
    for (int k = 0; k < 3000; k++) begin
      bus_rd(32'h30, st);
      bus_rd(32'h2C, rs);
      if (st[10] && !rs[31] && csn) break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(32'h2C, v); chk(v == 0, "R1 result", v, 0);
    bus_rd(32'h30, v); chk(v == 32'h400, "R1 status", v, 32'h400);
    bus_rd(32'h20, v); chk(v == 0, "R1 config", v, 0);
    chk(csn && !sclk, "R1 pins", {30'd0, csn, sclk}, 32'h2);

    // vector table: store, check slave, read back with echo
    for (int i = 0; i < 6; i++) begin
      logic [15:0] off, dat;
      off = VEC[i][31:16]; dat = VEC[i][15:0];
      bus_wr(WB + 32'(off), {16'hFFFF, dat});
      wait_idle();
      chk(!last_rw && last_addr == 15'(off >> 2) && last_data == dat, "R5 write frame",
          {last_rw, last_addr, last_data}, {1'b0, 15'(off >> 2), dat});
      bus_wr(32'h28, 32'(off));
      bus_rd(32'h2C, v);
      chk(v[31] && v[30:16] == 15'(off >> 2), "R2 busy and echo", v, {1'b1, 15'(off >> 2), 16'h0});
      wait_idle();
      bus_rd(32'h2C, v);
      exp = {1'b0, 15'(off >> 2), dat};
      chk(v == exp && last_rw, "R3 read result", v, exp);
    end

    // R4 ordering: read right after posted stores
    bus_wr(WB + 'h20, 32'h1111);
    bus_wr(WB + 'h24, 32'h2222);
    bus_wr(WB + 'h20, 32'h3333);
    bus_wr(32'h28, 32'h20);
    wait_idle();
    bus_rd(32'h2C, v);
    chk(v == {1'b0, 15'h8, 16'h3333}, "R4 read after writes", v, {1'b0, 15'h8, 16'h3333});

    // R9 second command while busy
    f0 = frames;
    bus_wr(32'h28, 32'h04);
    bus_wr(32'h28, 32'h10);
    wait_idle();
    bus_rd(32'h2C, v);
    chk(v == {1'b0, 15'h1, 16'hA1B2}, "R9 ignored command", v, {1'b0, 15'h1, 16'hA1B2});
    chk(frames == f0 + 1, "R9 frame count", 32'(frames - f0), 1);

    // R6 / R7 fill, overflow, drop
    for (int i = 0; i < 5; i++) bus_wr(WB + 'h80 + 4 * i, 32'hC000 + 32'(i));
    bus_rd(32'h30, v); chk(v == 32'h800, "R6 full flag", v, 32'h800);
    bus_wr(WB + 'h30, 32'hDEAD);
    bus_rd(32'h30, v); chk(v == 32'h1800, "R7 overflow set", v, 32'h1800);
    wait_idle();
    bus_rd(32'h30, v); chk(v == 32'h1400, "R7 overflow sticky", v, 32'h1400);
    bus_wr(32'h28, 32'h30);
    wait_idle();
    bus_rd(32'h2C, v);
    chk(v[15:0] == 16'h5A0C, "R7 dropped store absent", v, 32'h5A0C);
    bus_wr(32'h28, 32'h90);
    wait_idle();
    bus_rd(32'h2C, v);
    chk(v[15:0] == 16'hC004, "R6 last queued store delivered", v, 32'hC004);
    bus_wr(32'h30, 32'h1000);
    bus_rd(32'h30, v); chk(v == 32'h400, "R7 overflow clear", v, 32'h400);

    // R8 out-of-window stores
    f0 = frames;
    bus_wr(WB + WS, 32'hBEEF);
    bus_wr(WB - 4, 32'hBEEF);
    bus_rd(32'h30, v); chk(v == 32'h400, "R8 queue stays empty", v, 32'h400);
    repeat (200) @(negedge clk);
    chk(frames == f0, "R8 no frame", 32'(frames - f0), 0);

    // R11 clock modes
    bus_wr(32'h20, 32'h4000_0000);
    bus_rd(32'h20, v); chk(v == 32'h4000_0000, "R11 config readback", v, 32'h4000_0000);
    idle_edges = 0;
    repeat (40) @(negedge clk);
    chk(idle_edges >= 10, "R11 free-running clock", 32'(idle_edges), 10);
    bus_wr(WB + 'h44, 32'h6789);
    wait_idle();
    chk(last_addr == 15'h11 && last_data == 16'h6789, "R11 frame with clock on",
        {17'd0, last_addr}, 32'h11);
    bus_wr(32'h20, 32'h0);
    repeat (3) @(negedge clk);
    idle_edges = 0;
    repeat (40) @(negedge clk);
    chk(idle_edges == 0, "R11 gated clock", 32'(idle_edges), 0);

    // R10 framing
    chk(frame_err == 0, "R10 32 edges per frame", 32'(frame_err), 0);
    chk(mosi_err == 0, "R10 mosi stable while clock high", 32'(mosi_err), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule